// File: doc/BRIEF.md
# Rotating Register Stack with Tag Word

This block is an eight-entry register stack of the kind used by a floating-point unit. Each entry is 80 bits wide: a 64-bit fraction and a 16-bit sign/exponent field. A 3-bit top pointer turns a stack-relative index into a physical register number. A 16-bit tag word holds a 2-bit tag for every physical register. The surrounding datapath pushes and pops the stack, reads and writes entries by stack-relative index, and writes 64-bit packed values straight into a physical register.

The block also keeps a control word and a status word. Both are set by hardware reset and by an initialise command. The status word is always read with the live top pointer spliced into it. Each cycle a combinational decoder turns the five request inputs into one named operation: `OP_NONE`, `OP_PUSH`, `OP_POP`, `OP_WRITE`, `OP_PACK`, `OP_INIT` or `OP_CLASH`. The registered state then moves on the next clock edge:

- `OP_NONE` leaves the state as it is.
- `OP_PUSH` decrements the pointer.
- `OP_POP` marks the register at the top as empty and then increments the pointer.
- `OP_WRITE` performs a stack-relative store.
- `OP_PACK` performs a packed store.
- `OP_INIT` performs the initialise command.
- `OP_CLASH` changes nothing.

Top module: `rot_stack_rf`

## Requirements
- R1: The read port returns the fraction, sign/exponent and tag of physical register (top + rd_idx_i) mod 8. It is combinational and shows the state as of the last clock edge, so a write in the same cycle is not forwarded.
- R2: In the tag word, physical register n occupies bits 2n+1:2n. Tag value 3 means empty.
- R3: A lone push decrements the top pointer modulo 8. It changes no tag and no register contents.
- R4: A lone pop sets the tag of the physical register at the current top to 3. It then increments the top pointer modulo 8.
- R5: A lone stack-relative write stores the 64-bit fraction, the 16-bit sign/exponent and the supplied 2-bit tag into physical register (top + wr_idx_i) mod 8. No other tag bits change.
- R6: The status word equals the stored status, which is zero after reset or initialise, with bits 13:11 replaced by the current top pointer.
- R7: Initialise sets the control word to 0x037F, the status word and top pointer to 0, and the tag word to 0xFFFF. Register contents are left unchanged.
- R8: Hardware reset (rst_n low) sets the control word to 0x0040, the status word and top pointer to 0, the tag word to 0x5555, and every register to zero. Reset overrides any request.
- R9: A lone packed write stores pk_data_i as the fraction of physical register pk_phys_i, ignoring the top pointer. It sets that register's sign/exponent field to 0xFFFF and leaves its tag unchanged.
- R10: inv_mask_o equals bit 0 of the control word: 1 after initialise, 0 after reset.
- R11: When more than one of push, pop, write, packed write and initialise is requested in one cycle, conflict_o is 1 in that same cycle, and the clock edge changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| push_i | input | 1 | Push request |
| pop_i | input | 1 | Pop request |
| wr_i | input | 1 | Stack-relative write request |
| wr_idx_i | input | 3 | Stack-relative write index |
| wr_frac_i | input | 64 | Write fraction |
| wr_sexp_i | input | 16 | Write sign/exponent |
| wr_tag_i | input | 2 | Tag stored with the write |
| pk_i | input | 1 | Packed write request |
| pk_phys_i | input | 3 | Physical register index for the packed write |
| pk_data_i | input | 64 | Packed write data |
| init_i | input | 1 | Initialise request |
| rd_idx_i | input | 3 | Stack-relative read index |
| rd_frac_o | output | 64 | Read fraction |
| rd_sexp_o | output | 16 | Read sign/exponent |
| rd_tag_o | output | 2 | Read tag |
| ctrl_word_o | output | 16 | Control word |
| tag_word_o | output | 16 | Tag word |
| status_word_o | output | 16 | Status word with the top pointer in bits 13:11 |
| inv_mask_o | output | 1 | Control word bit 0 |
| conflict_o | output | 1 | More than one request this cycle |

## Verification
Only conflict_o and the read port react to the inputs in the same cycle. The read port follows rd_idx_i at once but shows register and tag state from the previous edge. Every operation's effect on the pointer, tags, words and entries appears one clock edge after the request, and reset acts at once. The bench drives inputs at the falling edge and lets the rising edge commit them. At the following falling edge it compares every output against a behavioural model that has taken the same edge, so a result is never sampled early or late.

// File: rtl/rot_stack_pkg.sv
package rot_stack_pkg;
    // Operation decoded from the request inputs each cycle
    typedef enum logic [2:0] {
        OP_NONE,
        OP_PUSH,
        OP_POP,
        OP_WRITE,
        OP_PACK,
        OP_INIT,
        OP_CLASH
    } op_e;

    localparam int          TAG_W      = 2;
    localparam logic [1:0]  TAG_EMPTY  = 2'b11;
    localparam logic [1:0]  TAG_RESET  = 2'b01;
    localparam logic [15:0] CTRL_INIT  = 16'h037F;
    localparam logic [15:0] CTRL_RESET = 16'h0040;
    localparam int          WORD_W     = 16;
    localparam int          TOP_LSB    = 11;
endpackage

// File: rtl/rs_op_decode.sv
module rs_op_decode
    import rot_stack_pkg::*;
(
    input  logic push_i,
    input  logic pop_i,
    input  logic wr_i,
    input  logic pk_i,
    input  logic init_i,
    output op_e  op_o,
    output logic clash_o
);
    logic [4:0] req;
    assign req = {init_i, pk_i, wr_i, pop_i, push_i};

    always_comb begin
        clash_o = ($countones(req) > 1);
        op_o    = OP_NONE;
        if (clash_o) begin
            op_o = OP_CLASH;
        end else begin
            unique case (req)
                5'b00000: op_o = OP_NONE;
                5'b00001: op_o = OP_PUSH;
                5'b00010: op_o = OP_POP;
                5'b00100: op_o = OP_WRITE;
                5'b01000: op_o = OP_PACK;
                5'b10000: op_o = OP_INIT;
                default:  op_o = OP_CLASH;
            endcase
        end
    end
endmodule

// File: rtl/rs_pointer.sv
module rs_pointer
    import rot_stack_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  op_e              op_i,
    input  logic [IDX_W-1:0] rd_idx_i,
    input  logic [IDX_W-1:0] wr_idx_i,
    output logic [IDX_W-1:0] top_o,
    output logic [IDX_W-1:0] rd_phys_o,
    output logic [IDX_W-1:0] wr_phys_o
);
    logic [IDX_W-1:0] top_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q <= '0;
        end else begin
            unique case (op_i)
                OP_PUSH: top_q <= top_q - 1'b1;
                OP_POP:  top_q <= top_q + 1'b1;
                OP_INIT: top_q <= '0;
                default: top_q <= top_q;
            endcase
        end
    end

    // Index widths wrap modulo the register count
    assign top_o     = top_q;
    assign rd_phys_o = top_q + rd_idx_i;
    assign wr_phys_o = top_q + wr_idx_i;
endmodule

// File: rtl/rs_tag_file.sv
module rs_tag_file
    import rot_stack_pkg::*;
#(
    parameter int NREG = 8,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  op_e              op_i,
    input  logic [IDX_W-1:0] top_i,
    input  logic [IDX_W-1:0] wr_phys_i,
    input  logic [TAG_W-1:0] wr_tag_i,
    input  logic [IDX_W-1:0] rd_phys_i,
    output logic [NREG*TAG_W-1:0] tag_word_o,
    output logic [TAG_W-1:0] rd_tag_o
);
    logic [TAG_W-1:0] tag_q [NREG];

    for (genvar n = 0; n < NREG; n++) begin : g_tag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tag_q[n] <= TAG_RESET;
            end else begin
                unique case (op_i)
                    OP_POP:   if (top_i == IDX_W'(n))     tag_q[n] <= TAG_EMPTY;
                    OP_WRITE: if (wr_phys_i == IDX_W'(n)) tag_q[n] <= wr_tag_i;
                    OP_INIT:  tag_q[n] <= TAG_EMPTY;
                    default:  tag_q[n] <= tag_q[n];
                endcase
            end
        end
        assign tag_word_o[n*TAG_W +: TAG_W] = tag_q[n];
    end

    assign rd_tag_o = tag_q[rd_phys_i];
endmodule

// File: rtl/rs_entry_bank.sv
module rs_entry_bank
    import rot_stack_pkg::*;
#(
    parameter int NREG   = 8,
    parameter int FRAC_W = 64,
    parameter int SEXP_W = 16,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  op_e               op_i,
    input  logic [IDX_W-1:0]  wr_phys_i,
    input  logic [FRAC_W-1:0] wr_frac_i,
    input  logic [SEXP_W-1:0] wr_sexp_i,
    input  logic [IDX_W-1:0]  pk_phys_i,
    input  logic [FRAC_W-1:0] pk_data_i,
    input  logic [IDX_W-1:0]  rd_phys_i,
    output logic [FRAC_W-1:0] rd_frac_o,
    output logic [SEXP_W-1:0] rd_sexp_o
);
    logic [FRAC_W-1:0] frac_q [NREG];
    logic [SEXP_W-1:0] sexp_q [NREG];

    for (genvar n = 0; n < NREG; n++) begin : g_ent
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                frac_q[n] <= '0;
                sexp_q[n] <= '0;
            end else if (op_i == OP_WRITE && wr_phys_i == IDX_W'(n)) begin
                frac_q[n] <= wr_frac_i;
                sexp_q[n] <= wr_sexp_i;
            end else if (op_i == OP_PACK && pk_phys_i == IDX_W'(n)) begin
                frac_q[n] <= pk_data_i;
                sexp_q[n] <= '1;
            end
        end
    end

    assign rd_frac_o = frac_q[rd_phys_i];
    assign rd_sexp_o = sexp_q[rd_phys_i];
endmodule

// File: rtl/rot_stack_rf.sv
module rot_stack_rf
    import rot_stack_pkg::*;
#(
    parameter int NREG   = 8,
    parameter int FRAC_W = 64,
    parameter int SEXP_W = 16,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic              pop_i,
    input  logic              wr_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic [FRAC_W-1:0] wr_frac_i,
    input  logic [SEXP_W-1:0] wr_sexp_i,
    input  logic [TAG_W-1:0]  wr_tag_i,
    input  logic              pk_i,
    input  logic [IDX_W-1:0]  pk_phys_i,
    input  logic [FRAC_W-1:0] pk_data_i,
    input  logic              init_i,
    input  logic [IDX_W-1:0]  rd_idx_i,
    output logic [FRAC_W-1:0] rd_frac_o,
    output logic [SEXP_W-1:0] rd_sexp_o,
    output logic [TAG_W-1:0]  rd_tag_o,
    output logic [WORD_W-1:0] ctrl_word_o,
    output logic [NREG*TAG_W-1:0] tag_word_o,
    output logic [WORD_W-1:0] status_word_o,
    output logic              inv_mask_o,
    output logic              conflict_o
);
    op_e              op;
    logic [IDX_W-1:0] top, rd_phys, wr_phys;
    logic [WORD_W-1:0] ctrl_q, stat_q;

    rs_op_decode u_dec (
        .push_i (push_i),
        .pop_i  (pop_i),
        .wr_i   (wr_i),
        .pk_i   (pk_i),
        .init_i (init_i),
        .op_o   (op),
        .clash_o(conflict_o)
    );

    rs_pointer #(.IDX_W(IDX_W)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_i     (op),
        .rd_idx_i (rd_idx_i),
        .wr_idx_i (wr_idx_i),
        .top_o    (top),
        .rd_phys_o(rd_phys),
        .wr_phys_o(wr_phys)
    );

    rs_tag_file #(.NREG(NREG)) u_tag (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_i      (op),
        .top_i     (top),
        .wr_phys_i (wr_phys),
        .wr_tag_i  (wr_tag_i),
        .rd_phys_i (rd_phys),
        .tag_word_o(tag_word_o),
        .rd_tag_o  (rd_tag_o)
    );

    rs_entry_bank #(.NREG(NREG), .FRAC_W(FRAC_W), .SEXP_W(SEXP_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_i     (op),
        .wr_phys_i(wr_phys),
        .wr_frac_i(wr_frac_i),
        .wr_sexp_i(wr_sexp_i),
        .pk_phys_i(pk_phys_i),
        .pk_data_i(pk_data_i),
        .rd_phys_i(rd_phys),
        .rd_frac_o(rd_frac_o),
        .rd_sexp_o(rd_sexp_o)
    );

    // Control and stored status words
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RESET;
            stat_q <= '0;
        end else if (op == OP_INIT) begin
            ctrl_q <= CTRL_INIT;
            stat_q <= '0;
        end
    end

    always_comb begin
        status_word_o = stat_q;
        status_word_o[TOP_LSB +: IDX_W] = top;
    end

    assign ctrl_word_o = ctrl_q;
    assign inv_mask_o  = ctrl_q[0];
endmodule

// File: rtl/rot_stack_chk.sv
module rot_stack_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        push_i,
    input logic        pop_i,
    input logic        wr_i,
    input logic        pk_i,
    input logic        init_i,
    input logic [15:0] ctrl_word_o,
    input logic [15:0] tag_word_o,
    input logic [15:0] status_word_o,
    input logic        inv_mask_o,
    input logic        conflict_o
);
    logic [4:0] req;
    logic       sole;
    assign req  = {init_i, pk_i, wr_i, pop_i, push_i};
    assign sole = ($countones(req) == 1);

    // R3
    push_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && sole) |=> (status_word_o[13:11] == 3'($past(status_word_o[13:11]) - 3'd1))
                             && $stable(tag_word_o));

    // R4
    pop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && sole) |=> status_word_o[13:11] == 3'($past(status_word_o[13:11]) + 3'd1));

    // R4
    pop_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && sole) |=> ((tag_word_o >> {$past(status_word_o[13:11]), 1'b0}) & 16'h0003) == 16'h0003);

    // R11
    clash_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conflict_o |=> $stable(status_word_o) && $stable(tag_word_o) && $stable(ctrl_word_o));

    // R7
    init_words_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (init_i && sole) |=> ctrl_word_o == 16'h037F && tag_word_o == 16'hFFFF && status_word_o == 16'h0000);

    // R10
    init_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (init_i && sole) |=> inv_mask_o);

    // R8
    reset_words_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> ctrl_word_o == 16'h0040 && tag_word_o == 16'h5555
                         && status_word_o == 16'h0000 && !inv_mask_o);
endmodule

bind rot_stack_rf rot_stack_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .push_i       (push_i),
    .pop_i        (pop_i),
    .wr_i         (wr_i),
    .pk_i         (pk_i),
    .init_i       (init_i),
    .ctrl_word_o  (ctrl_word_o),
    .tag_word_o   (tag_word_o),
    .status_word_o(status_word_o),
    .inv_mask_o   (inv_mask_o),
    .conflict_o   (conflict_o)
);

// File: tb/rot_stack_rf_tb.sv
`timescale 1ns/1ps
module rot_stack_rf_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push_i = 0, pop_i = 0, wr_i = 0, pk_i = 0, init_i = 0;
    logic [2:0]  wr_idx_i = 0, pk_phys_i = 0, rd_idx_i = 0;
    logic [63:0] wr_frac_i = 0, pk_data_i = 0;
    logic [15:0] wr_sexp_i = 0;
    logic [1:0]  wr_tag_i = 0;
    logic [63:0] rd_frac_o;
    logic [15:0] rd_sexp_o, ctrl_word_o, tag_word_o, status_word_o;
    logic [1:0]  rd_tag_o;
    logic        inv_mask_o, conflict_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    rot_stack_rf u_dut (
        .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i), .wr_i(wr_i),
        .wr_idx_i(wr_idx_i), .wr_frac_i(wr_frac_i), .wr_sexp_i(wr_sexp_i),
        .wr_tag_i(wr_tag_i), .pk_i(pk_i), .pk_phys_i(pk_phys_i), .pk_data_i(pk_data_i),
        .init_i(init_i), .rd_idx_i(rd_idx_i), .rd_frac_o(rd_frac_o), .rd_sexp_o(rd_sexp_o),
        .rd_tag_o(rd_tag_o), .ctrl_word_o(ctrl_word_o), .tag_word_o(tag_word_o),
        .status_word_o(status_word_o), .inv_mask_o(inv_mask_o), .conflict_o(conflict_o)
    );

    // Behavioural reference model
    logic [79:0] m_reg [8];
    logic [1:0]  m_tag [8];
    int          m_top;
    logic [15:0] m_ctrl;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < 8; k++) begin m_reg[k] = '0; m_tag[k] = 2'd1; end
            m_top = 0; m_ctrl = 16'h0040;
        end else if (push_i + pop_i + wr_i + pk_i + init_i == 1) begin
            if (push_i) m_top = (m_top + 7) % 8;
            if (pop_i) begin m_tag[m_top] = 2'd3; m_top = (m_top + 1) % 8; end
            if (wr_i) begin
                m_reg[(m_top + wr_idx_i) % 8] = {wr_frac_i, wr_sexp_i};
                m_tag[(m_top + wr_idx_i) % 8] = wr_tag_i;
            end
            if (pk_i) m_reg[pk_phys_i] = {pk_data_i, 16'hFFFF};
            if (init_i) begin
                m_ctrl = 16'h037F; m_top = 0;
                for (int k = 0; k < 8; k++) m_tag[k] = 2'd3;
            end
        end
    end

    function automatic logic [15:0] m_tword();
        logic [15:0] w;
        for (int k = 0; k < 8; k++) w[2*k +: 2] = m_tag[k];
        return w;
    endfunction

    task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Compare every output with the model
    task automatic compare_all();
        chk("R1 read value", {rd_frac_o, rd_sexp_o}, m_reg[(m_top + rd_idx_i) % 8]);
        chk("R1 read tag", rd_tag_o, m_tag[(m_top + rd_idx_i) % 8]);
        chk("R2 tag word", tag_word_o, m_tword());
        chk("R6 status word", status_word_o, {2'b00, 3'(m_top), 11'b0});
        chk("R10 control/mask", {ctrl_word_o, inv_mask_o}, {m_ctrl, m_ctrl[0]});
        chk("R11 conflict flag", conflict_o, (push_i + pop_i + wr_i + pk_i + init_i) > 1);
    endtask

    task automatic cycle();
        @(posedge clk);
        @(negedge clk);
        compare_all();
        {push_i, pop_i, wr_i, pk_i, init_i} = '0;
    endtask

    task automatic sweep();
        for (int i = 0; i < 8; i++) begin
            rd_idx_i = 3'(i);
            #0.1;
            chk("R1 sweep", {rd_frac_o, rd_sexp_o, rd_tag_o},
                {m_reg[(m_top + i) % 8], m_tag[(m_top + i) % 8]});
        end
    endtask

    task automatic do_write(int idx, logic [63:0] f, logic [15:0] s, logic [1:0] t);
        wr_i = 1; wr_idx_i = 3'(idx); wr_frac_i = f; wr_sexp_i = s; wr_tag_i = t;
        cycle();
    endtask

    function automatic logic [63:0] vf(int k);
        return {56'h0123_4567_89AB_CD, 8'(k)};
    endfunction

    initial begin
        logic [15:0] tw;
        @(negedge clk); @(negedge clk);
        // R8 reset state
        chk("R8 reset ctrl", ctrl_word_o, 16'h0040);
        chk("R8 reset tags", tag_word_o, 16'h5555);
        chk("R8 reset status", status_word_o, 16'h0000);
        chk("R10 mask after reset", inv_mask_o, 1'b0);
        rst_n = 1;
        @(negedge clk);
        sweep();
        // Fill: at top 0, idx k lands in phys k with tag k%3
        for (int k = 0; k < 8; k++) do_write(k, vf(k), 16'(16'h4000 + k), 2'(k % 3));
        tw = '0;
        for (int k = 0; k < 8; k++) tw[2*k +: 2] = 2'(k % 3);
        chk("R5 tags after fill", tag_word_o, tw);
        // R3 three pushes wrap top from 0 to 5
        for (int k = 0; k < 3; k++) begin push_i = 1; cycle(); end
        chk("R3 top after pushes", status_word_o[13:11], 3'd5);
        chk("R3 tags unchanged", tag_word_o, tw);
        rd_idx_i = 0; #0.1;
        chk("R1 idx0 maps to phys5", {rd_frac_o, rd_tag_o}, {vf(5), 2'd2});
        // R5 write idx2 at top5 -> phys7, tag 1
        do_write(2, 64'hFEED_FACE_CAFE_BEEF, 16'hC001, 2'd1);
        tw[15:14] = 2'd1;
        chk("R5 only phys7 tag bits", tag_word_o, tw);
        rd_idx_i = 2; #0.1;
        chk("R5 stored value", {rd_frac_o, rd_sexp_o}, {64'hFEED_FACE_CAFE_BEEF, 16'hC001});
        // R1 no forwarding: read phys0 while writing it
        rd_idx_i = 3; wr_i = 1; wr_idx_i = 3; wr_frac_i = 64'h1; wr_sexp_i = 16'h2; wr_tag_i = 2'd2;
        #0.1;
        chk("R1 no forwarding", rd_frac_o, vf(0));
        cycle();
        chk("R1 after edge", rd_frac_o, 64'h1);
        tw[1:0] = 2'd2;
        // R4 pop marks phys5 empty, top 6
        pop_i = 1; cycle();
        tw[11:10] = 2'd3;
        chk("R4 pop tag", tag_word_o, tw);
        chk("R4 pop top", status_word_o, 16'h3000);
        // R9 packed write phys2, read via idx4 (6+4=2)
        pk_i = 1; pk_phys_i = 2; pk_data_i = 64'h0102_0304_0506_0708; cycle();
        rd_idx_i = 4; #0.1;
        chk("R9 packed value", {rd_frac_o, rd_sexp_o, rd_tag_o},
            {64'h0102_0304_0506_0708, 16'hFFFF, 2'd2});
        chk("R9 tags unchanged", tag_word_o, tw);
        // R11 clash: push and pop together
        push_i = 1; pop_i = 1; #0.1;
        chk("R11 conflict raised", conflict_o, 1'b1);
        cycle();
        chk("R11 top held", status_word_o[13:11], 3'd6);
        chk("R11 tags held", tag_word_o, tw);
        // R7 initialise
        init_i = 1; cycle();
        chk("R7 ctrl", ctrl_word_o, 16'h037F);
        chk("R7 tags", tag_word_o, 16'hFFFF);
        chk("R7 status", status_word_o, 16'h0000);
        chk("R10 mask after init", inv_mask_o, 1'b1);
        rd_idx_i = 7; #0.1;
        chk("R7 contents kept", rd_frac_o, 64'hFEED_FACE_CAFE_BEEF);
        push_i = 1; cycle();
        chk("R3 wrap 0 to 7", status_word_o[13:11], 3'd7);
        sweep();
        // Mixed stimulus compared against the model
        for (int c = 0; c < 400; c++) begin
            int r;
            r = int'($urandom % 16);
            rd_idx_i = 3'($urandom);
            wr_idx_i = 3'($urandom); pk_phys_i = 3'($urandom); wr_tag_i = 2'($urandom);
            wr_frac_i = {$urandom, $urandom}; wr_sexp_i = 16'($urandom);
            pk_data_i = {$urandom, $urandom};
            if (r < 3) push_i = 1;
            else if (r < 6) pop_i = 1;
            else if (r < 10) wr_i = 1;
            else if (r < 12) pk_i = 1;
            else if (r == 12) init_i = 1;
            else if (r == 13) begin wr_i = 1; pk_i = 1; end
            cycle();
        end
        sweep();
        // R8 reset mid-run
        rst_n = 0; #1;
        chk("R8 async reset ctrl", ctrl_word_o, 16'h0040);
        @(negedge clk); rst_n = 1;
        chk("R8 tags", tag_word_o, 16'h5555);
        chk("R8 status", status_word_o, 16'h0000);
        sweep();
        for (int i = 0; i < 8; i++) begin
            rd_idx_i = 3'(i); #0.1;
            chk("R8 entry zero", {rd_frac_o, rd_sexp_o}, 80'h0);
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule